// File: doc/BRIEF.md
# Five-Channel Buffered Down-Counter Bank

This block provides five independent 32-bit down-counters behind a small synchronous register bus. Every channel has a count buffer, and channels 0 to 3 also have a compare buffer. Software writes the buffers first. It then sets the channel's manual-update bit in the shared control word, which copies the buffers into the live counter and the live compare register. Finally it rewrites the control word with update clear and start set. The live counter changes only through a manual-update copy, a decrement, or an auto-reload at expiry. This double buffering lets software prepare the next period while the current one runs.

Each channel advances by one on a single-cycle tick-enable input of its own, so the clock divider stays outside the block. A channel expires when a tick arrives while its count is zero. On expiry it pulses its interrupt line for one clock and latches a sticky status bit. With auto-reload set, it reloads from its buffers and keeps running. With auto-reload clear, it stops, and the hardware clears its start bit.

A live count that equals the compare value toggles a per-channel level output when a tick is consumed. Every live count can be read back through an observation address.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous active-high reset, all of the following are zero: control word, buffers, counters, status, `irq_o` and `cmp_lvl_o`.
- R2: Register map, byte addresses:
  - Control word: 0x08.
  - Status: 0x44.
  - Count buffers: 0x0C, 0x18, 0x24 and 0x30 for channels 0 to 3, and 0x3C for channel 4.
  - Compare buffers: 0x10, 0x1C, 0x28 and 0x34 for channels 0 to 3.
  - Observation addresses (live count): 0x14, 0x20, 0x2C and 0x38 for channels 0 to 3, and 0x40 for channel 4.
  - Writes to an observation address are ignored, and unmapped addresses read zero.
- R3: Control word fields:
  - Channel 0 has start at bit 0, update at bit 1 and reload at bit 3.
  - Channels 1, 2 and 3 have their fields at base bits 8, 12 and 16, with start at base+0, update at base+1 and reload at base+3.
  - Channel 4 has start at bit 20, update at bit 21 and reload at bit 22.
  - All other bits are not stored and read zero.
- R4: On every clock edge where a channel's update bit is 1, the live counter and compare register load from the buffers. Ticks have no effect on that channel during such cycles.
- R5: A channel decrements by one on a tick only while start is 1 and update is 0. With start 0 the count holds.
- R6: A buffer value N gives expiry on the (N+1)-th consumed tick. The all-ones buffer value counts down through the full 32-bit range.
- R7: With reload 1, expiry reloads the counter (and compare register) from the buffers and counting continues.
- R8: With reload 0, expiry leaves the count at zero and clears the channel's start bit in the control word. A bus write to the control word in that same cycle takes priority.
- R9: `irq_o[c]` is high for exactly the one clock that follows the edge on which channel c expires.
- R10: Status bit c (bits 4:0 at 0x44) sets on expiry of channel c and is cleared by writing 1 to it. A set in the same cycle as a clear leaves the bit set.
- R11: For channels 0 to 3, a consumed tick while the live count equals the live compare value toggles `cmp_lvl_o[c]`. `cmp_lvl_o[4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_i | input | 5 | Per-channel tick enable, one bit per channel |
| irq_o | output | 5 | Per-channel one-clock expiry pulse |
| cmp_lvl_o | output | 5 | Per-channel compare toggle level |

## Verification
Two functions can fall in the same cycle: a channel's expiry setting its status bit, and a bus write of 1 clearing that same bit. The bench provokes this directly. It runs a periodic channel down to zero and issues the write-one-to-clear on exactly the edge that consumes the expiring tick. It expects the bit to read back as still set, and then expects a later plain clear to empty it. The random phase drives ticks and status clears independently on every cycle. A bench model that applies the clear before the set judges each status read, and the same model also covers the one-shot start clear against simultaneous control writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH = 5;
    localparam int AW  = 8;
    localparam int DW  = 32;

    localparam logic [AW-1:0] ADDR_CTRL = 8'h08;
    localparam logic [AW-1:0] ADDR_STAT = 8'h44;

    typedef struct packed {
        logic start;
        logic upd;
        logic rld;
    } chan_ctl_t;

    // lowest bit of a channel's field in the control word
    function automatic int fld_lsb(input int ch);
        return (ch == 0) ? 0 : 4 + 4 * ch;
    endfunction

    // the last channel has a 3-bit field, reload sits one place lower
    function automatic int rld_pos(input int ch);
        return fld_lsb(ch) + ((ch == NCH - 1) ? 2 : 3);
    endfunction

    function automatic logic [AW-1:0] cnt_buf_addr(input int ch);
        return (ch == NCH - 1) ? 8'h3C : AW'(12 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] cmp_buf_addr(input int ch);
        return AW'(16 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] obs_addr(input int ch);
        return (ch == NCH - 1) ? 8'h40 : AW'(20 + 12 * ch);
    endfunction

    function automatic logic [DW-1:0] ctrl_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int c = 0; c < NCH; c++) begin
            m[fld_lsb(c)]     = 1'b1;
            m[fld_lsb(c) + 1] = 1'b1;
            m[rld_pos(c)]     = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wdata,
    input  logic [NCH-1:0]       stop_req,
    output logic [DW-1:0]        word_q,
    output chan_ctl_t [NCH-1:0]  ctl
);
    localparam logic [DW-1:0] MASK = ctrl_mask();

    logic [DW-1:0] stop_bits;

    always_comb begin
        stop_bits = '0;
        for (int c = 0; c < NCH; c++) begin
            stop_bits[fld_lsb(c)] = stop_req[c];
        end
    end

    // a bus write replaces the whole word, so it wins over a one-shot stop
    always_ff @(posedge clk) begin
        if (rst)        word_q <= '0;
        else if (wr_en) word_q <= wdata & MASK;
        else            word_q <= word_q & ~stop_bits;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_fld
        assign ctl[g].start = word_q[fld_lsb(g)];
        assign ctl[g].upd   = word_q[fld_lsb(g) + 1];
        assign ctl[g].rld   = word_q[rld_pos(g)];

        AST_ONESHOT_CLEARS_START: assert property (@(posedge clk) disable iff (rst)
            (!wr_en && stop_req[g]) |=> !word_q[fld_lsb(g)]); // R8
    end
endmodule

// File: rtl/tmr_status.sv
module tmr_status
    import tmr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_en,
    input  logic [NCH-1:0] clr_bits,
    input  logic [NCH-1:0] set_bits,
    output logic [NCH-1:0] stat_q
);
    logic [NCH-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_bits : '0;

    // clear first, then set: a coincident expiry keeps its bit
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_eff) | set_bits;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_STAT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_bits[g] |=> stat_q[g]); // R10
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW      = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  chan_ctl_t     ctl,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_buf_q,
    output logic [CW-1:0] cmp_buf_q,
    output logic [CW-1:0] cnt_q,
    output logic          irq_q,
    output logic          lvl_q,
    output logic          stop_req
);
    logic consume;
    logic expire;

    assign consume  = ctl.start && !ctl.upd && tick;
    assign expire   = consume && (cnt_q == '0);
    assign stop_req = expire && !ctl.rld;

    always_ff @(posedge clk) begin
        if (rst)         cnt_buf_q <= '0;
        else if (wr_cnt) cnt_buf_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (ctl.upd)     cnt_q <= cnt_buf_q;
        else if (expire) begin
            if (ctl.rld)      cnt_q <= cnt_buf_q;
        end
        else if (consume)     cnt_q <= cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= expire;
    end

    if (HAS_CMP) begin : g_cmp
        logic [CW-1:0] cmp_q;

        always_ff @(posedge clk) begin
            if (rst)         cmp_buf_q <= '0;
            else if (wr_cmp) cmp_buf_q <= wdata;
        end

        always_ff @(posedge clk) begin
            if (rst)                       cmp_q <= '0;
            else if (ctl.upd)              cmp_q <= cmp_buf_q;
            else if (expire && ctl.rld)    cmp_q <= cmp_buf_q;
        end

        always_ff @(posedge clk) begin
            if (rst)                               lvl_q <= 1'b0;
            else if (consume && (cnt_q == cmp_q))  lvl_q <= ~lvl_q;
        end
    end else begin : g_nocmp
        logic unused_cmp;
        assign unused_cmp = wr_cmp;
        assign cmp_buf_q  = '0;
        assign lvl_q      = 1'b0;
    end

    AST_UPD_LOADS_BUF: assert property (@(posedge clk) disable iff (rst)
        $past(ctl.upd) |-> (cnt_q == $past(cnt_buf_q))); // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.start && !ctl.upd) |=> $stable(cnt_q)); // R5
    AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (rst)
        (consume && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
    AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (($past(cnt_q) == '0) && $past(tick))); // R9
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] tick_i,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] cmp_lvl_o
);
    chan_ctl_t [NCH-1:0] ctl;
    logic [DW-1:0]       ctrl_word;
    logic [NCH-1:0]      stop_req;
    logic [NCH-1:0]      stat_q;
    logic [CW-1:0]       cntb [NCH];
    logic [CW-1:0]       cmpb [NCH];
    logic [CW-1:0]       cnt  [NCH];

    tmr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && (bus_addr == ADDR_CTRL)),
        .wdata    (bus_wdata),
        .stop_req (stop_req),
        .word_q   (ctrl_word),
        .ctl      (ctl)
    );

    tmr_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (bus_wr && (bus_addr == ADDR_STAT)),
        .clr_bits (bus_wdata[NCH-1:0]),
        .set_bits (irq_set),
        .stat_q   (stat_q)
    );

    logic [NCH-1:0] irq_set;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ch_irq;
        logic ch_lvl;
        logic ch_stop;

        tmr_chan #(
            .CW      (CW),
            .HAS_CMP (g < NCH - 1)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_i[g]),
            .ctl       (ctl[g]),
            .wr_cnt    (bus_wr && (bus_addr == cnt_buf_addr(g))),
            .wr_cmp    (bus_wr && (g < NCH - 1) && (bus_addr == cmp_buf_addr(g))),
            .wdata     (bus_wdata[CW-1:0]),
            .cnt_buf_q (cntb[g]),
            .cmp_buf_q (cmpb[g]),
            .cnt_q     (cnt[g]),
            .irq_q     (ch_irq),
            .lvl_q     (ch_lvl),
            .stop_req  (ch_stop)
        );

        assign irq_o[g]     = ch_irq;
        assign cmp_lvl_o[g] = ch_lvl;
        assign stop_req[g]  = ch_stop;
        // expiry is visible one cycle early as the stop/reload condition;
        // the status register samples the registered pulse's cause directly
        assign irq_set[g]   = ch_stop || (ctl[g].rld && ctl[g].start && !ctl[g].upd
                                          && tick_i[g] && (cnt[g] == '0));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_word;
        if (bus_addr == ADDR_STAT) bus_rdata = DW'(stat_q);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == cnt_buf_addr(c)) bus_rdata = DW'(cntb[c]);
            if ((c < NCH - 1) && (bus_addr == cmp_buf_addr(c))) bus_rdata = DW'(cmpb[c]);
            if (bus_addr == obs_addr(c)) bus_rdata = DW'(cnt[c]);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_top_chk
        AST_IRQ_MATCHES_STAT: assert property (@(posedge clk) disable iff (rst)
            irq_o[g] |-> stat_q[g]); // R10
    end
endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;
    localparam logic [31:0] MASK     = 32'h007B_BB0B;
    localparam logic [31:0] UPD_BITS = 32'h0022_2202;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [4:0]  tick;
    logic [4:0]  irq_o;
    logic [4:0]  cmp_lvl_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr_bank u_tmr_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_i    (tick),
        .irq_o     (irq_o),
        .cmp_lvl_o (cmp_lvl_o)
    );

    function automatic int fl(input int c);  return (c == 0) ? 0 : 4 + 4 * c; endfunction
    function automatic int rp(input int c);  return fl(c) + ((c == 4) ? 2 : 3); endfunction
    function automatic logic [7:0] acnt(input int c); return (c == 4) ? 8'h3C : 8'(12 + 12 * c); endfunction
    function automatic logic [7:0] acmp(input int c); return 8'(16 + 12 * c); endfunction
    function automatic logic [7:0] aobs(input int c); return (c == 4) ? 8'h40 : 8'(20 + 12 * c); endfunction

    // reference model, built from the requirements
    logic [31:0] m_cnt [5];
    logic [31:0] m_cm  [5];
    logic [31:0] m_cb  [5];
    logic [31:0] m_mb  [5];
    logic [31:0] m_ctrl;
    logic [4:0]  m_irq, m_lvl, m_stat;

    always @(posedge clk) begin : mdl
        logic [4:0] stopv;
        logic [4:0] setv;
        if (rst) begin
            for (int c = 0; c < 5; c++) begin
                m_cnt[c] = 0; m_cm[c] = 0; m_cb[c] = 0; m_mb[c] = 0;
            end
            m_ctrl = 0; m_irq = 0; m_lvl = 0; m_stat = 0;
        end else begin
            stopv = 0; setv = 0;
            for (int c = 0; c < 5; c++) begin
                m_irq[c] = 1'b0;
                if (m_ctrl[fl(c) + 1]) begin
                    m_cnt[c] = m_cb[c];
                    m_cm[c]  = (c < 4) ? m_mb[c] : 32'h0;
                end else if (m_ctrl[fl(c)] && tick[c]) begin
                    if (c < 4 && m_cnt[c] == m_cm[c]) m_lvl[c] = ~m_lvl[c];
                    if (m_cnt[c] == 0) begin
                        m_irq[c] = 1'b1;
                        setv[c]  = 1'b1;
                        if (m_ctrl[rp(c)]) begin
                            m_cnt[c] = m_cb[c];
                            m_cm[c]  = (c < 4) ? m_mb[c] : 32'h0;
                        end else begin
                            stopv[c] = 1'b1;
                        end
                    end else begin
                        m_cnt[c] = m_cnt[c] - 1;
                    end
                end
            end
            if (bus_wr && bus_addr == 8'h44) m_stat = m_stat & ~bus_wdata[4:0];
            m_stat = m_stat | setv;
            if (bus_wr && bus_addr == 8'h08) m_ctrl = bus_wdata & MASK;
            else for (int c = 0; c < 5; c++) if (stopv[c]) m_ctrl[fl(c)] = 1'b0;
            for (int c = 0; c < 5; c++) begin
                if (bus_wr && bus_addr == acnt(c)) m_cb[c] = bus_wdata;
                if (bus_wr && c < 4 && bus_addr == acmp(c)) m_mb[c] = bus_wdata;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r;
        r = 0;
        if (a == 8'h08) r = m_ctrl;
        if (a == 8'h44) r = {27'h0, m_stat};
        for (int c = 0; c < 5; c++) begin
            if (a == acnt(c)) r = m_cb[c];
            if (c < 4 && a == acmp(c)) r = m_mb[c];
            if (a == aobs(c)) r = m_cnt[c];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [4:0] t);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick = t;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 5'b0);
    endtask

    task automatic rd(input logic [7:0] a);
        step(1'b0, a, 32'h0, 5'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pulses;
        void'($urandom(32'd1357));
        rst = 1'b1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; tick = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(8'h08); chk("R1 ctrl", bus_rdata, 0);
        rd(8'h14); chk("R1 count0", bus_rdata, 0);
        rd(8'h44); chk("R1 status", bus_rdata, 0);
        chk("R1 irq/lvl", {22'h0, irq_o, cmp_lvl_o}, 0);

        // register map
        wr(8'h18, 32'h1234); wr(8'h1C, 32'h55); wr(8'h3C, 32'h77);
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h18); chk("R2 cntbuf1", bus_rdata, 32'h1234);
        rd(8'h1C); chk("R2 cmpbuf1", bus_rdata, 32'h55);
        rd(8'h3C); chk("R2 cntbuf4", bus_rdata, 32'h77);
        rd(8'h20); chk("R2 obs write ignored", bus_rdata, 0);
        rd(8'h00); chk("R2 unmapped", bus_rdata, 0);

        // field layout, manual update copies, ticks ignored while updating
        wr(8'h08, 32'hFFFF_FFFF);
        step(1'b0, 8'h08, 0, 5'b11111);
        chk("R3 ctrl mask", bus_rdata, MASK);
        wr(8'h08, 32'h0);
        rd(8'h20); chk("R4 copy ch1", bus_rdata, 32'h1234);
        rd(8'h40); chk("R4 copy ch4", bus_rdata, 32'h77);

        // start gating
        repeat (3) step(1'b0, 8'h20, 0, 5'b00010);
        chk("R5 halted holds", bus_rdata, 32'h1234);
        wr(8'h08, 32'h100);
        repeat (3) step(1'b0, 8'h20, 0, 5'b00010);
        chk("R5 decrement", bus_rdata, 32'h1231);
        wr(8'h08, 32'h0);
        step(1'b0, 8'h20, 0, 5'b00010);
        chk("R5 stop holds", bus_rdata, 32'h1231);

        // one-shot, period N+1
        wr(8'h0C, 32'd3); wr(8'h08, 32'h2); rd(8'h14); wr(8'h08, 32'h1);
        repeat (3) step(1'b0, 8'h14, 0, 5'b00001);
        chk("R6 no early irq", {31'h0, irq_o[0]}, 0);
        step(1'b0, 8'h14, 0, 5'b00001);
        chk("R9 irq on tick N+1", {31'h0, irq_o[0]}, 1);
        step(1'b0, 8'h14, 0, 5'b00001);
        chk("R9 single pulse", {31'h0, irq_o[0]}, 0);
        chk("R8 count stays zero", bus_rdata, 0);
        rd(8'h08); chk("R8 start cleared", bus_rdata, 0);

        // periodic
        wr(8'h24, 32'd2); wr(8'h08, 32'h2000); rd(8'h2C); wr(8'h08, 32'h9000);
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            step(1'b0, 8'h2C, 0, 5'b00100);
            if (irq_o[2]) pulses++;
        end
        chk("R7 periodic pulses", pulses, 3);
        chk("R7 reloaded", bus_rdata, 32'd2);

        // status and collision with expiry
        rd(8'h44); chk("R10 status set", bus_rdata, 32'h5);
        wr(8'h44, 32'h1);
        rd(8'h44); chk("R10 w1c", bus_rdata, 32'h4);
        step(1'b0, 8'h2C, 0, 5'b00100);
        step(1'b0, 8'h2C, 0, 5'b00100);
        step(1'b1, 8'h44, 32'h4, 5'b00100);
        chk("R9 irq at collision", {31'h0, irq_o[2]}, 1);
        rd(8'h44); chk("R10 set wins over clear", bus_rdata, 32'h4);
        wr(8'h44, 32'h4);
        rd(8'h44); chk("R10 plain clear", bus_rdata, 0);

        // compare toggle
        wr(8'h30, 32'd4); wr(8'h34, 32'd2); wr(8'h08, 32'h20000); rd(8'h38); wr(8'h08, 32'h90000);
        repeat (2) step(1'b0, 8'h38, 0, 5'b01000);
        chk("R11 before match", {31'h0, cmp_lvl_o[3]}, 0);
        step(1'b0, 8'h38, 0, 5'b01000);
        chk("R11 toggled", {31'h0, cmp_lvl_o[3]}, 1);
        chk("R11 ch4 level", {31'h0, cmp_lvl_o[4]}, 0);

        // full-range wrap on channel 4
        wr(8'h3C, 32'hFFFF_FFFF); wr(8'h08, 32'h20_0000); rd(8'h40); wr(8'h08, 32'h50_0000);
        repeat (2) step(1'b0, 8'h40, 0, 5'b10000);
        chk("R6 max value", bus_rdata, 32'hFFFF_FFFD);
        wr(8'h08, 32'h0);

        // constrained random against the model
        for (int i = 0; i < 4000; i++) begin
            int sel;
            int c;
            logic [7:0] ra;
            logic [4:0] tk;
            sel = $urandom % 8;
            c   = $urandom % 5;
            tk  = 5'($urandom);
            case (sel)
                0: step(1'b1, 8'h08,
                        ($urandom & MASK) & (($urandom % 4 != 0) ? ~UPD_BITS : 32'hFFFF_FFFF), tk);
                1: step(1'b1, acnt(c), ($urandom % 8 == 0) ? 32'hFFFF_FFFF : 32'($urandom % 6), tk);
                2: step(1'b1, acmp(c % 4), 32'($urandom % 6), tk);
                3: step(1'b1, 8'h44, 32'($urandom % 32), tk);
                default: begin
                    case ($urandom % 5)
                        0: ra = 8'h08;
                        1: ra = 8'h44;
                        2: ra = acnt(c);
                        3: ra = (c < 4) ? acmp(c) : 8'h00;
                        default: ra = aobs(c);
                    endcase
                    step(1'b0, ra, 0, tk);
                    chk("R2 random read", bus_rdata, m_read(ra));
                end
            endcase
            chk("R9 random irq", {27'h0, irq_o}, {27'h0, m_irq});
            chk("R11 random level", {27'h0, cmp_lvl_o}, {27'h0, m_lvl});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule